// File: doc/BRIEF.md
# Fuse Array Controller

The block fronts a one-time-programmable fuse store of 8 banks by 256 words of 8 bits. Software reaches it over a simple word-addressed 32-bit register bus. A small set of control registers lets software burn one fuse bit per operation and run explicit sense cycles that fetch the raw contents of one fuse word. A mapped window covering the whole array returns each word's effective value on reads and replaces that value on writes.

Program and sense operations run for a fixed, parameterised number of cycles. A busy flag is visible for that whole time. Completion and error conditions land in sticky flag registers, which software clears by writing ones. Each flag can be routed to a single interrupt line through a matching mask register. Three per-bank input vectors protect banks against programming, window reads and window overrides. Programming also needs a key byte to be present in a dedicated key register.

Top module: `fuse_ctrl_top`

## Requirements
- R1: After reset every register reads zero, every window word reads zero and `irq` is low. The register word addresses are: 0 status, 1 status mask, 2 error, 3 error mask, 4 control, 5 high address, 6 low address, 7 sense data, 8 key. Other register addresses read zero.
- R2: The target fuse comes from two registers. The high address holds the bank in bits 5:3 and word bits 7:5 in bits 2:0. The low address holds word bits 4:0 in bits 7:3 and the bit number in bits 2:0. A completed program sets exactly that one bit.
- R3: Writing control bit 0 starts a program only when the key register holds 0xAA. Otherwise the request is refused, error bit 7 is set and nothing starts.
- R4: Status bit 7 reads one for exactly OP_CYCLES cycles after an accepted start. When the operation ends, status bit 1 is set for a program and status bit 0 is set for a sense.
- R5: Writing control bit 3 starts a sense. When it ends, the sense-data register holds the raw fuse word at the addressed location, whatever any override has done to its effective value.
- R6: A start request made while the block is busy has no effect and raises no error. When bits 0 and 3 are written together, only the program is taken.
- R7: A program aimed at a bank whose `wp_bank` bit is high is refused. It sets error bit 6, starts nothing, sets no status bit 1 and changes no fuse.
- R8: Reading word address 0x800 + bank*256 + word returns the effective value of that word in bits 7:0. If the bank's `rp_bank` bit is high, the read returns zero and sets error bit 4.
- R9: Writing through the window replaces the word's effective value with wdata bits 7:0 and leaves the raw fuse word alone. If the bank's `op_bank` bit is high, the write is dropped and error bit 5 is set.
- R10: Status bits 1:0 and error bits 7:1 are sticky. Writing a one to a bit clears it, and writing a zero leaves it unchanged.
- R11: `irq` is high exactly when some set status bit among 1:0 has its status-mask bit set, or some set error bit among 7:1 has its error-mask bit set.
- R12: A completed program ORs its bit into both the raw and the effective word. Fuse bits only ever go from 0 to 1, and other bits of the word are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Word address: registers below 0x800, array window above |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| wp_bank | input | 8 | Per-bank program protection |
| rp_bank | input | 8 | Per-bank window read protection |
| op_bank | input | 8 | Per-bank override protection |
| irq | output | 1 | Masked flag interrupt |

## Verification
The hardest state to reach is a start request landing inside a running operation, including the edge on which that operation completes. The bench issues a sense and follows it at once with program and sense requests while status bit 7 is still high. It then checks that no error is raised and that only the first operation's flag appears. The bench also builds a word whose effective and raw values differ by overriding it and then programming a further bit. Sense data and window reads must then disagree in the way R5 and R12 predict.

// File: rtl/fuse_pkg.sv
// Shared constants for the fuse controller: register word addresses,
// flag bit positions and the programming key. Assumes 8-bit flag fields.
package fuse_pkg;
    localparam logic [3:0] RA_STAT = 4'd0;
    localparam logic [3:0] RA_SMSK = 4'd1;
    localparam logic [3:0] RA_ERR  = 4'd2;
    localparam logic [3:0] RA_EMSK = 4'd3;
    localparam logic [3:0] RA_CTRL = 4'd4;
    localparam logic [3:0] RA_ADRH = 4'd5;
    localparam logic [3:0] RA_ADRL = 4'd6;
    localparam logic [3:0] RA_SDAT = 4'd7;
    localparam logic [3:0] RA_KEY  = 4'd8;

    localparam logic [7:0] PRG_KEY    = 8'hAA;
    localparam logic [7:0] STAT_BITS  = 8'h03;
    localparam logic [7:0] ERR_BITS   = 8'hFE;
    localparam logic [7:0] CTRL_KEEP  = 8'hF6;
    localparam logic [7:0] ADRH_BITS  = 8'h3F;

    localparam int unsigned EB_PRG = 7;
    localparam int unsigned EB_WP  = 6;
    localparam int unsigned EB_OVR = 5;
    localparam int unsigned EB_RD  = 4;
    localparam int unsigned CB_PRG = 0;
    localparam int unsigned CB_SNS = 3;

    typedef enum logic {OP_SNS = 1'b0, OP_PRG = 1'b1} op_kind_e;
endpackage

// File: rtl/fuse_seq.sv
// Operation sequencer: holds busy for OP_CYCLES cycles after a start and
// flags the last busy cycle. Assumes starts arrive only while idle, one at a time.
module fuse_seq
    import fuse_pkg::*;
#(
    parameter int unsigned OP_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     go_prg,
    input  logic     go_sns,
    output logic     busy,
    output logic     done,
    output op_kind_e kind
);
    localparam int unsigned CNT_W = $clog2(OP_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    // Load the counter on a start, count down while busy, drop busy at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            cnt_q <= '0;
            kind  <= OP_SNS;
        end else if (!busy) begin
            if (go_prg || go_sns) begin
                busy  <= 1'b1;
                cnt_q <= CNT_W'(OP_CYCLES - 1);
                kind  <= go_prg ? OP_PRG : OP_SNS;
            end
        end else if (cnt_q == '0) begin
            busy <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // The final busy cycle is the completion cycle.
    assign done = busy && (cnt_q == '0);

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (go_prg || go_sns) |-> !busy) else $error("start while busy"); // R6
    AST_ONE_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(go_prg && go_sns)) else $error("two starts"); // R6
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy) else $error("busy after done"); // R4
endmodule

// File: rtl/fuse_array.sv
// Behavioural fuse store: a raw array that only gains ones, and an
// effective array that window writes may replace. Assumes 8-bit words.
module fuse_array #(
    parameter int unsigned BANKS = 8,
    parameter int unsigned WORDS = 256
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  prg_en,
    input  logic [$clog2(BANKS*WORDS)-1:0]        prg_idx,
    input  logic [2:0]                            prg_bit,
    input  logic                                  ovr_en,
    input  logic [$clog2(BANKS*WORDS)-1:0]        ovr_idx,
    input  logic [7:0]                            ovr_data,
    input  logic [$clog2(BANKS*WORDS)-1:0]        win_idx,
    output logic [7:0]                            win_eff,
    input  logic [$clog2(BANKS*WORDS)-1:0]        sns_idx,
    output logic [7:0]                            sns_raw
);
    localparam int unsigned DEPTH = BANKS * WORDS;

    logic [7:0] raw_mem [DEPTH];
    logic [7:0] eff_mem [DEPTH];
    logic [7:0] bit_mask;
    logic       same_idx;

    assign bit_mask = 8'(1) << prg_bit;
    assign same_idx = prg_en && ovr_en && (prg_idx == ovr_idx);

    // Clear on reset; OR programmed bits in, apply overrides to the effective copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                raw_mem[i] <= '0;
                eff_mem[i] <= '0;
            end
        end else begin
            if (prg_en)
                raw_mem[prg_idx] <= raw_mem[prg_idx] | bit_mask;
            if (ovr_en)
                eff_mem[ovr_idx] <= ovr_data | (same_idx ? bit_mask : 8'h00);
            if (prg_en && !same_idx)
                eff_mem[prg_idx] <= eff_mem[prg_idx] | bit_mask;
        end
    end

    assign win_eff = eff_mem[win_idx];
    assign sns_raw = raw_mem[sns_idx];

    AST_FUSE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        prg_en |=> raw_mem[$past(prg_idx)][$past(prg_bit)]) else $error("bit not burnt"); // R12
endmodule

// File: rtl/fuse_regs.sv
// Register file and bus decode: flags, masks, address and key registers,
// start qualification, protection checks and interrupt. Assumes the default
// 8x256 geometry for the address register layout.
module fuse_regs
    import fuse_pkg::*;
#(
    parameter int unsigned BANKS = 8,
    parameter int unsigned WORDS = 256
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  bus_sel,
    input  logic                                  bus_wr,
    input  logic [$clog2(BANKS*WORDS):0]          bus_addr,
    input  logic [31:0]                           bus_wdata,
    output logic [31:0]                           bus_rdata,
    input  logic [BANKS-1:0]                      wp_bank,
    input  logic [BANKS-1:0]                      rp_bank,
    input  logic [BANKS-1:0]                      op_bank,
    input  logic                                  busy,
    input  logic                                  done,
    input  op_kind_e                              kind,
    output logic                                  go_prg,
    output logic                                  go_sns,
    output logic                                  prg_en,
    output logic [$clog2(BANKS*WORDS)-1:0]        op_idx,
    output logic [2:0]                            op_bit,
    output logic                                  ovr_en,
    output logic [$clog2(BANKS*WORDS)-1:0]        win_idx,
    input  logic [7:0]                            win_eff,
    input  logic [7:0]                            sns_raw,
    output logic                                  irq
);
    localparam int unsigned BANK_W = $clog2(BANKS);
    localparam int unsigned IDX_W  = $clog2(BANKS * WORDS);
    localparam int unsigned ADDR_W = IDX_W + 1;

    logic [7:0] stat_q, smsk_q, err_q, emsk_q, ctrl_q, adrh_q, adrl_q, sdat_q, key_q;
    logic [7:0] stat_set, stat_clr, err_set, err_clr, wbyte;
    logic       in_win, reg_ok, wr_reg, rd_win, wr_win;
    logic       req_prg, req_sns, key_ok, cur_wp;
    logic [3:0] reg_off;
    logic [BANK_W-1:0] win_bank, cur_bank;
    logic [IDX_W-1:0]  cur_idx;
    logic [23:0] unused_wdata;

    assign unused_wdata = bus_wdata[31:8];
    assign wbyte    = bus_wdata[7:0];
    assign in_win   = bus_addr[ADDR_W-1];
    assign reg_ok   = (bus_addr[ADDR_W-2:4] == '0);
    assign reg_off  = bus_addr[3:0];
    assign wr_reg   = bus_sel && bus_wr && !in_win && reg_ok;
    assign rd_win   = bus_sel && !bus_wr && in_win;
    assign wr_win   = bus_sel && bus_wr && in_win;
    assign win_idx  = bus_addr[IDX_W-1:0];
    assign win_bank = bus_addr[IDX_W-1 -: BANK_W];

    // Target location as assembled from the two address registers.
    assign cur_idx  = IDX_W'({adrh_q[5:0], adrl_q[7:3]});
    assign cur_bank = cur_idx[IDX_W-1 -: BANK_W];
    assign cur_wp   = wp_bank[cur_bank];
    assign key_ok   = (key_q == PRG_KEY);

    // Start requests are only looked at while idle; program outranks sense.
    assign req_prg = wr_reg && (reg_off == RA_CTRL) && wbyte[CB_PRG] && !busy;
    assign req_sns = wr_reg && (reg_off == RA_CTRL) && wbyte[CB_SNS] && !wbyte[CB_PRG] && !busy;
    assign go_prg  = req_prg && key_ok && !cur_wp;
    assign go_sns  = req_sns;

    assign prg_en = done && (kind == OP_PRG);
    assign ovr_en = wr_win && !op_bank[win_bank];

    // Gather flag set and write-one-to-clear terms for this cycle.
    always_comb begin
        stat_set = '0;
        err_set  = '0;
        stat_set[1] = prg_en;
        stat_set[0] = done && (kind == OP_SNS);
        err_set[EB_PRG] = req_prg && !key_ok;
        err_set[EB_WP]  = req_prg && key_ok && cur_wp;
        err_set[EB_RD]  = rd_win && rp_bank[win_bank];
        err_set[EB_OVR] = wr_win && op_bank[win_bank];
        stat_clr = (wr_reg && reg_off == RA_STAT) ? (wbyte & STAT_BITS) : 8'h00;
        err_clr  = (wr_reg && reg_off == RA_ERR)  ? (wbyte & ERR_BITS)  : 8'h00;
    end

    // Register writes, sticky flags, operation address latch and sense capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0; smsk_q <= '0; err_q <= '0; emsk_q <= '0; ctrl_q <= '0;
            adrh_q <= '0; adrl_q <= '0; sdat_q <= '0; key_q <= '0;
            op_idx <= '0; op_bit <= '0;
        end else begin
            stat_q <= (stat_q & ~stat_clr) | stat_set;
            err_q  <= (err_q & ~err_clr) | err_set;
            if (wr_reg) begin
                case (reg_off)
                    RA_SMSK: smsk_q <= wbyte & STAT_BITS;
                    RA_EMSK: emsk_q <= wbyte & ERR_BITS;
                    RA_CTRL: ctrl_q <= wbyte & CTRL_KEEP;
                    RA_ADRH: adrh_q <= wbyte & ADRH_BITS;
                    RA_ADRL: adrl_q <= wbyte;
                    RA_KEY:  key_q  <= wbyte;
                    default: ;
                endcase
            end
            if (go_prg || go_sns) begin
                op_idx <= cur_idx;
                op_bit <= adrl_q[2:0];
            end
            if (done && kind == OP_SNS)
                sdat_q <= sns_raw;
        end
    end

    // Read mux: window words or registers, zero-extended to the bus.
    always_comb begin
        bus_rdata = '0;
        if (in_win) begin
            bus_rdata[7:0] = rp_bank[win_bank] ? 8'h00 : win_eff;
        end else if (reg_ok) begin
            case (reg_off)
                RA_STAT: bus_rdata[7:0] = {busy, stat_q[6:0]};
                RA_SMSK: bus_rdata[7:0] = smsk_q;
                RA_ERR:  bus_rdata[7:0] = err_q;
                RA_EMSK: bus_rdata[7:0] = emsk_q;
                RA_CTRL: bus_rdata[7:0] = ctrl_q;
                RA_ADRH: bus_rdata[7:0] = adrh_q;
                RA_ADRL: bus_rdata[7:0] = adrl_q;
                RA_SDAT: bus_rdata[7:0] = sdat_q;
                RA_KEY:  bus_rdata[7:0] = key_q;
                default: bus_rdata = '0;
            endcase
        end
    end

    assign irq = |(stat_q & smsk_q) || |(err_q & emsk_q);

    AST_KEY_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_reg && reg_off == RA_CTRL && wbyte[CB_PRG] && !busy && key_q != PRG_KEY)
        |=> (err_q[EB_PRG] && !busy)) else $error("program without key"); // R3
    AST_WP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_prg && key_ok && wp_bank[cur_bank]) |=> (err_q[EB_WP] && !busy)) else $error("wp ignored"); // R7
    AST_PRGD_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (done && kind == OP_PRG) |=> stat_q[1]) else $error("no program done flag"); // R4
    AST_RD_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win && rp_bank[win_bank]) |-> (bus_rdata == 32'h0)) else $error("protected read leaked"); // R8
    AST_OVR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_win && op_bank[win_bank]) |=> err_q[EB_OVR]) else $error("override error missing"); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q == 8'h00 && err_q == 8'h00) |-> !irq) else $error("spurious irq"); // R11
endmodule

// File: rtl/fuse_ctrl_top.sv
// Top of the fuse controller: wires the register file, the sequencer and
// the storage array together. Assumes a single-cycle bus with no wait states.
module fuse_ctrl_top
    import fuse_pkg::*;
#(
    parameter int unsigned BANKS     = 8,
    parameter int unsigned WORDS     = 256,
    parameter int unsigned OP_CYCLES = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_sel,
    input  logic                            bus_wr,
    input  logic [$clog2(BANKS*WORDS):0]    bus_addr,
    input  logic [31:0]                     bus_wdata,
    output logic [31:0]                     bus_rdata,
    input  logic [BANKS-1:0]                wp_bank,
    input  logic [BANKS-1:0]                rp_bank,
    input  logic [BANKS-1:0]                op_bank,
    output logic                            irq
);
    localparam int unsigned IDX_W = $clog2(BANKS * WORDS);

    logic             go_prg, go_sns, busy, done, prg_en, ovr_en;
    op_kind_e         kind;
    logic [IDX_W-1:0] op_idx, win_idx;
    logic [2:0]       op_bit;
    logic [7:0]       win_eff, sns_raw;

    fuse_regs #(.BANKS(BANKS), .WORDS(WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wp_bank(wp_bank), .rp_bank(rp_bank), .op_bank(op_bank),
        .busy(busy), .done(done), .kind(kind), .go_prg(go_prg), .go_sns(go_sns),
        .prg_en(prg_en), .op_idx(op_idx), .op_bit(op_bit), .ovr_en(ovr_en),
        .win_idx(win_idx), .win_eff(win_eff), .sns_raw(sns_raw), .irq(irq)
    );

    fuse_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .go_prg(go_prg), .go_sns(go_sns),
        .busy(busy), .done(done), .kind(kind)
    );

    fuse_array #(.BANKS(BANKS), .WORDS(WORDS)) u_array (
        .clk(clk), .rst_n(rst_n), .prg_en(prg_en), .prg_idx(op_idx), .prg_bit(op_bit),
        .ovr_en(ovr_en), .ovr_idx(win_idx), .ovr_data(bus_wdata[7:0]),
        .win_idx(win_idx), .win_eff(win_eff), .sns_idx(op_idx), .sns_raw(sns_raw)
    );
endmodule

// File: tb/test_fuse_ctrl_top.sv
module test_fuse_ctrl_top;
    localparam int OPC = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [7:0]  wp, rp, op;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fuse_ctrl_top #(.BANKS(8), .WORDS(256), .OP_CYCLES(OPC)) i_fuse_ctrl_top (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wp_bank(wp), .rp_bank(rp), .op_bank(op), .irq(irq)
    );

    // Behavioural reference state.
    logic [7:0] m_raw [0:2047];
    logic [7:0] m_eff [0:2047];
    logic [7:0] m_stat, m_smsk, m_err, m_emsk, m_ctrl, m_adrh, m_adrl, m_sdat, m_key;
    bit m_busy, m_isprg;
    int m_left, m_oidx, m_obit;

    function automatic logic [31:0] mread(input logic [11:0] a);
        if (a[11]) return rp[a[10:8]] ? 32'h0 : {24'h0, m_eff[a[10:0]]};
        case (int'(a[10:0]))
            0: return {24'h0, m_busy, 5'b0, m_stat[1:0]};
            1: return {24'h0, m_smsk};
            2: return {24'h0, m_err};
            3: return {24'h0, m_emsk};
            4: return {24'h0, m_ctrl};
            5: return {24'h0, m_adrh};
            6: return {24'h0, m_adrl};
            7: return {24'h0, m_sdat};
            8: return {24'h0, m_key};
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin : model
        logic dn, sp, ss;
        logic [7:0] sset, sclr, eset, eclr, bm;
        int idx, cidx;
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) begin m_raw[i] = 0; m_eff[i] = 0; end
            m_stat = 0; m_smsk = 0; m_err = 0; m_emsk = 0; m_ctrl = 0;
            m_adrh = 0; m_adrl = 0; m_sdat = 0; m_key = 0;
            m_busy = 0; m_isprg = 0; m_left = 0; m_oidx = 0; m_obit = 0;
        end else begin
            dn = m_busy && (m_left == 1);
            sp = 0; ss = 0; sset = 0; sclr = 0; eset = 0; eclr = 0;
            idx = int'(bus_addr[10:0]);
            cidx = int'({m_adrh[5:0], m_adrl[7:3]});
            if (bus_sel && bus_wr && !bus_addr[11]) begin
                case (idx)
                    0: sclr = bus_wdata[7:0] & 8'h03;
                    1: m_smsk = bus_wdata[7:0] & 8'h03;
                    2: eclr = bus_wdata[7:0] & 8'hFE;
                    3: m_emsk = bus_wdata[7:0] & 8'hFE;
                    4: begin
                        m_ctrl = bus_wdata[7:0] & 8'hF6;
                        if (!m_busy && bus_wdata[0]) begin
                            if (m_key != 8'hAA) eset[7] = 1;
                            else if (wp[m_adrh[5:3]]) eset[6] = 1;
                            else sp = 1;
                        end else if (!m_busy && bus_wdata[3]) ss = 1;
                    end
                    5: m_adrh = bus_wdata[7:0] & 8'h3F;
                    6: m_adrl = bus_wdata[7:0];
                    8: m_key = bus_wdata[7:0];
                    default: ;
                endcase
            end
            if (bus_sel && !bus_wr && bus_addr[11] && rp[bus_addr[10:8]]) eset[4] = 1;
            if (bus_sel && bus_wr && bus_addr[11]) begin
                if (op[bus_addr[10:8]]) eset[5] = 1;
                else m_eff[idx] = bus_wdata[7:0];
            end
            if (dn) begin
                m_busy = 0;
                if (m_isprg) begin
                    bm = 8'(1) << m_obit;
                    m_raw[m_oidx] = m_raw[m_oidx] | bm;
                    m_eff[m_oidx] = m_eff[m_oidx] | bm;
                    sset[1] = 1;
                end else begin
                    m_sdat = m_raw[m_oidx];
                    sset[0] = 1;
                end
            end else if (m_busy) begin
                m_left = m_left - 1;
            end
            if (sp || ss) begin
                m_busy = 1; m_left = OPC; m_isprg = sp;
                m_oidx = cidx; m_obit = int'(m_adrl[2:0]);
            end
            m_stat = (m_stat & ~sclr) | sset;
            m_err  = (m_err & ~eclr) | eset;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Interrupt compared against the reference on every cycle (R11).
    always @(negedge clk) begin
        if (rst_n && !finished)
            chk("R11 irq", {31'h0, irq},
                {31'h0, (|(m_stat & m_smsk)) || (|(m_err & m_emsk))});
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic rd(input string req, input logic [11:0] a);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 chk(req, bus_rdata, mread(a));
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rd_exp(input string req, input logic [11:0] a, input logic [7:0] e);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 chk(req, bus_rdata, {24'h0, e});
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_addr(input int bank, input int word, input int bitn);
        wr(12'h005, 32'((bank << 3) | (word >> 5)));
        wr(12'h006, 32'(((word & 31) << 3) | bitn));
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        wp = 0; rp = 0; op = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset contents
        for (int a = 0; a < 10; a++) rd_exp("R1 reset reg", 12'(a), 8'h00);
        rd_exp("R1 reset window", 12'h800, 8'h00);
        rd_exp("R1 reset window", 12'hFFF, 8'h00);
        chk("R1 irq low", {31'h0, irq}, 32'h0);

        // R3: program without key refused
        set_addr(2, 8'h5A, 5);
        wr(12'h004, 32'h01);
        rd_exp("R3 no busy", 12'h000, 8'h00);
        rd_exp("R3 key error", 12'h002, 8'h80);
        rd_exp("R3 fuse untouched", 12'h800 + 2*256 + 8'h5A, 8'h00);
        // R11 and R10: mask, then clear
        wr(12'h003, 32'h80);
        idle(1);
        chk("R11 irq on error", {31'h0, irq}, 32'h1);
        wr(12'h002, 32'h00);
        rd_exp("R10 zero write keeps", 12'h002, 8'h80);
        wr(12'h002, 32'h80);
        rd_exp("R10 one write clears", 12'h002, 8'h00);

        // R2 R4: keyed program of bank 2 word 0x5A bit 5
        wr(12'h008, 32'hAA);
        wr(12'h004, 32'h01);
        rd_exp("R4 busy set", 12'h000, 8'h80);
        idle(OPC);
        rd_exp("R4 program done", 12'h000, 8'h02);
        rd_exp("R2 single bit", 12'h800 + 2*256 + 8'h5A, 8'h20);
        rd_exp("R2 neighbour word", 12'h800 + 2*256 + 8'h5B, 8'h00);
        rd_exp("R2 other bank", 12'h800 + 3*256 + 8'h5A, 8'h00);

        // R12: second bit keeps the first
        set_addr(2, 8'h5A, 0);
        wr(12'h004, 32'h01);
        idle(OPC + 1);
        rd_exp("R12 bits accumulate", 12'h800 + 2*256 + 8'h5A, 8'h21);

        // R5 R6: sense, with starts during busy
        wr(12'h000, 32'h03);
        set_addr(2, 8'h5A, 7);
        wr(12'h004, 32'h08);
        wr(12'h004, 32'h01);
        wr(12'h004, 32'h08);
        idle(OPC);
        rd_exp("R5 sense data", 12'h007, 8'h21);
        rd_exp("R6 only sense done", 12'h000, 8'h01);
        rd_exp("R6 no error", 12'h002, 8'h00);
        rd_exp("R6 bit 7 not burnt", 12'h800 + 2*256 + 8'h5A, 8'h21);
        // R6: both starts together, program wins
        wr(12'h000, 32'h03);
        wr(12'h004, 32'h09);
        idle(OPC + 1);
        rd_exp("R6 program won", 12'h000, 8'h02);
        rd_exp("R6 bit 7 burnt", 12'h800 + 2*256 + 8'h5A, 8'hA1);

        // R9 R5 R12: override differs from raw
        wr(12'h800 + 2*256 + 8'h5A, 32'h0F);
        rd_exp("R9 override visible", 12'h800 + 2*256 + 8'h5A, 8'h0F);
        wr(12'h004, 32'h08);
        idle(OPC + 1);
        rd_exp("R5 sense ignores override", 12'h007, 8'hA1);
        set_addr(2, 8'h5A, 4);
        wr(12'h004, 32'h01);
        idle(OPC + 1);
        rd_exp("R12 program ORs into override", 12'h800 + 2*256 + 8'h5A, 8'h1F);

        // R9: override-protected bank
        op = 8'h08;
        wr(12'h800 + 3*256 + 1, 32'h55);
        rd_exp("R9 dropped", 12'h800 + 3*256 + 1, 8'h00);
        rd_exp("R9 error", 12'h002, 8'h20);

        // R8: read-protected bank
        set_addr(4, 0, 1);
        wr(12'h004, 32'h01);
        idle(OPC + 1);
        rp = 8'h10;
        wr(12'h002, 32'hFE);
        rd_exp("R8 protected reads zero", 12'h800 + 4*256, 8'h00);
        rd_exp("R8 error", 12'h002, 8'h10);
        wr(12'h004, 32'h08);
        idle(OPC + 1);
        rd_exp("R5 sense of protected bank", 12'h007, 8'h02);

        // R7: write-protected bank
        wp = 8'h20;
        wr(12'h000, 32'h03);
        wr(12'h002, 32'hFE);
        set_addr(5, 8'h10, 3);
        wr(12'h004, 32'h01);
        rd_exp("R7 no busy", 12'h000, 8'h00);
        idle(OPC + 1);
        rd_exp("R7 error", 12'h002, 8'h40);
        rd_exp("R7 no done", 12'h000, 8'h00);
        rd_exp("R7 no change", 12'h800 + 5*256 + 8'h10, 8'h00);

        // R11: status mask routing
        wp = 8'h00;
        wr(12'h001, 32'h01);
        wr(12'h004, 32'h01);
        idle(OPC + 1);
        chk("R11 unmasked done", {31'h0, irq}, 32'h0);
        wr(12'h004, 32'h08);
        idle(OPC + 1);
        chk("R11 masked done", {31'h0, irq}, 32'h1);

        // Sweep register reads against the model
        for (int a = 0; a < 12; a++) rd("R1 map", 12'(a));

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule